// File: doc/BRIEF.md
# Performance Event Selector Register Bank

This block holds the machine-mode selector registers that tell a set of hardware performance counters what to count. There are 29 of them, 64 bits each, numbered 0 to 28 (serving counters 3 to 31). Software updates one selector at a time through a write port that carries an index, an enable and 64 bits of data. Each selector then keeps only the legal part of what was written. The three 5-bit combine-operation fields are checked one by one, and a field given an unsupported code keeps its previous contents. The bits that cannot be written always read as zero.

The counter logic reports overflows through a 29-bit vector and a load strobe. When the strobe is high, the overflow flag of every selector is loaded from its bit of the vector in the same cycle. A combinational read port returns the selector chosen by a read index. The reset input is asserted asynchronously, is active low, and is released in step with the clock through a two-stage synchronizer inside the block.

Top module: `perf_sel_bank`

## Requirements
- R1: While reset is held, and after it is released until the first write, every selector reads as 0.
- R2: A write with `wr_en` high to an index in 0..28 changes only that selector. The new value is on `rd_data` from the first clock edge after the write cycle, and `rd_data` follows `rd_idx` combinationally. With `wr_en` low, no selector changes.
- R3: Bits 57:55 of every selector are not writable and always read 0. Bit 63 (overflow), bits 62:58 (counting inhibits for M, S, U, VS and VU mode) and bits 39:0 (four 10-bit event identifiers at 39:30, 29:20, 19:10 and 9:0) take the written data unchanged.
- R4: The operation fields sit at bits 44:40 (field 0), 49:45 (field 1) and 54:50 (field 2). The legal codes are 0 (OR), 1 (AND), 2 (XOR) and 4 (ADD). A written field that holds a legal code is stored. A written field that holds any other code leaves that field at its old value. Each field is judged on its own, so the other fields of the same write still take effect.
- R5: A cycle with `ovf_load` high copies `ovf_vec[i]` into bit 63 of selector i for all i at once and leaves every other bit unchanged.
- R6: When a write and `ovf_load` reach the same selector in the same cycle, bit 63 takes `ovf_vec[i]` and all other bits follow the write rules of R3 and R4.
- R7: A write to an index of 29 or above changes no selector, and a read of such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_idx | input | 5 | Selector index for the write |
| wr_data | input | 64 | Write data before legalization |
| ovf_load | input | 1 | Strobe that loads all overflow flags |
| ovf_vec | input | 29 | New overflow flag for each selector |
| rd_idx | input | 5 | Selector index for the read |
| rd_data | output | 64 | Contents of the indexed selector, or 0 |

## Verification
A software write and a hardware overflow load can land on the same selector in the same clock cycle. The bench provokes this by holding `wr_en` and `ovf_load` together for one cycle. The write data carries an overflow bit that is the opposite of the vector bit for the targeted selector. Afterwards the bench reads the targeted selector and several others. The flag must come from the vector while every other bit carries the legalized write data, and every other selector must show only its new flag.

// File: rtl/perf_sel_pkg.sv
package perf_sel_pkg;
  localparam int SEL_W    = 64;
  localparam int OP_W     = 5;
  localparam int NUM_OPS  = 3;
  localparam int OP_LSB0  = 40;
  localparam int OVF_BIT  = 63;
  localparam int LOCK_LSB = 55;
  localparam int LOCK_W   = 3;
  localparam logic [SEL_W-1:0] SEL_WMASK = ~(((SEL_W)'(1) << LOCK_W) - 1 << LOCK_LSB);

  function automatic logic op_code_ok(input logic [OP_W-1:0] code);
    return (code == 5'd0) || (code == 5'd1) || (code == 5'd2) || (code == 5'd4);
  endfunction
endpackage

// File: rtl/perf_sel_rst_sync.sv
module perf_sel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/perf_sel_legal.sv
module perf_sel_legal
  import perf_sel_pkg::*;
(
  input  logic [SEL_W-1:0] old_q,
  input  logic [SEL_W-1:0] wr_data,
  output logic [SEL_W-1:0] new_q
);
  logic [NUM_OPS-1:0] code_ok;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op_chk
    localparam int LSB = OP_LSB0 + k * OP_W;
    assign code_ok[k] = op_code_ok(wr_data[LSB +: OP_W]);
  end

  always_comb begin
    new_q = wr_data & SEL_WMASK;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (!code_ok[k]) begin
        new_q[OP_LSB0 + k * OP_W +: OP_W] = old_q[OP_LSB0 + k * OP_W +: OP_W];
      end
    end
  end
endmodule

// File: rtl/perf_sel_slot.sv
module perf_sel_slot
  import perf_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [SEL_W-1:0] wr_data,
  input  logic             ovf_load,
  input  logic             ovf_bit,
  output logic [SEL_W-1:0] q
);
  logic [SEL_W-1:0] legal_val;
  logic [SEL_W-1:0] d;
  logic             en;

  perf_sel_legal u_legal (
    .old_q   (q),
    .wr_data (wr_data),
    .new_q   (legal_val)
  );

  always_comb begin
    en = wr_hit | ovf_load;
    d  = wr_hit ? legal_val : q;
    if (ovf_load) d[OVF_BIT] = ovf_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  assert_locked_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q[LOCK_LSB +: LOCK_W] == '0);

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op_chk
    localparam int LSB = OP_LSB0 + k * OP_W;
    assert_op_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      op_code_ok(q[LSB +: OP_W]));
    assert_keep_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !op_code_ok(wr_data[LSB +: OP_W])) |=> $stable(q[LSB +: OP_W]));
  end

  assert_ovf_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_load |=> q[OVF_BIT] == $past(ovf_bit));

  assert_ovf_only_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_load && !wr_hit) |=> $stable(q[OVF_BIT-1:0]));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_load && !wr_hit) |=> $stable(q));
endmodule

// File: rtl/perf_sel_bank.sv
module perf_sel_bank
  import perf_sel_pkg::*;
#(
  parameter int NUM_SEL = 29,
  localparam int IDX_W  = $clog2(NUM_SEL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [SEL_W-1:0]   wr_data,
  input  logic               ovf_load,
  input  logic [NUM_SEL-1:0] ovf_vec,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [SEL_W-1:0]   rd_data
);
  logic                          rst_sync_n;
  logic [NUM_SEL-1:0][SEL_W-1:0] sel_q;
  logic [NUM_SEL-1:0]            hit;

  perf_sel_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_slot
    assign hit[i] = wr_en && (wr_idx == IDX_W'(i));
    perf_sel_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .wr_hit   (hit[i]),
      .wr_data  (wr_data),
      .ovf_load (ovf_load),
      .ovf_bit  (ovf_vec[i]),
      .q        (sel_q[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = sel_q[i];
    end
  end

  assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(hit));

  assert_range_ignored_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (int'(wr_idx) >= NUM_SEL) && !ovf_load) |=> $stable(sel_q));

  assert_range_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(rd_idx) >= NUM_SEL) |-> (rd_data == '0));
endmodule

// File: tb/test_perf_sel_bank.sv
module test_perf_sel_bank;
  localparam int N = 29;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  logic        ovf_load;
  logic [N-1:0] ovf_vec;
  logic [4:0]  rd_idx;
  logic [63:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [N];

  always #10 clk = ~clk;

  perf_sel_bank i_perf_sel_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ovf_load(ovf_load), .ovf_vec(ovf_vec), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic logic good_op(input logic [4:0] c);
    return c == 5'd0 || c == 5'd1 || c == 5'd2 || c == 5'd4;
  endfunction

  function automatic logic [63:0] apply_write(input logic [63:0] old, input logic [63:0] w);
    logic [63:0] r;
    r = w;
    r[57:55] = 3'b000;
    if (!good_op(w[44:40])) r[44:40] = old[44:40];
    if (!good_op(w[49:45])) r[49:45] = old[49:45];
    if (!good_op(w[54:50])) r[54:50] = old[54:50];
    return r;
  endfunction

  task automatic check_sel(input int idx, input logic [63:0] exp, input string req);
    @(negedge clk);
    rd_idx = 5'(idx);
    #2;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s idx %0d actual %h expected %h", req, idx, rd_data, exp);
    end
  endtask

  task automatic cycle(input logic we, input int idx, input logic [63:0] d,
                       input logic ol, input logic [N-1:0] v);
    @(negedge clk);
    wr_en = we; wr_idx = 5'(idx); wr_data = d; ovf_load = ol; ovf_vec = v;
    @(negedge clk);
    wr_en = 1'b0; ovf_load = 1'b0;
    if (we && idx < N) model[idx] = apply_write(model[idx], d);
    if (ol) for (int i = 0; i < N; i++) model[i][63] = v[i];
  endtask

  task automatic t_reset;
    for (int i = 0; i < N; i += 7) check_sel(i, 64'h0, "R1");
    check_sel(28, 64'h0, "R1");
  endtask

  task automatic t_basic_write;
    cycle(1'b1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0);
    check_sel(3, model[3], "R3");
    check_sel(2, 64'h0, "R2");
    cycle(1'b1, 0, 64'h83E0_0000_ABCD_1234, 1'b0, '0);
    check_sel(0, model[0], "R3");
    cycle(1'b0, 0, 64'h1234_5678_9ABC_DEF0, 1'b0, '0);
    check_sel(0, model[0], "R2");
  endtask

  task automatic t_ops;
    logic [63:0] w;
    w = '0; w[44:40] = 5'd4; w[49:45] = 5'd1; w[54:50] = 5'd2; w[9:0] = 10'h155;
    cycle(1'b1, 10, w, 1'b0, '0);
    check_sel(10, model[10], "R4");
    w = '0; w[44:40] = 5'd3; w[49:45] = 5'd0; w[54:50] = 5'd7; w[39:30] = 10'h2AA;
    cycle(1'b1, 10, w, 1'b0, '0);
    check_sel(10, model[10], "R4");
    w = '0; w[44:40] = 5'd2; w[49:45] = 5'd31; w[54:50] = 5'd4;
    cycle(1'b1, 10, w, 1'b0, '0);
    check_sel(10, model[10], "R4");
  endtask

  task automatic t_overflow;
    cycle(1'b0, 0, '0, 1'b1, 29'h1555_5555);
    for (int i = 0; i < N; i += 5) check_sel(i, model[i], "R5");
    check_sel(10, model[10], "R5");
  endtask

  task automatic t_collision;
    logic [63:0] w;
    w = 64'h8000_0000_0000_0000 | 64'h0400_0000_0000_00FF;
    w[49:45] = 5'd2;
    cycle(1'b1, 5, w, 1'b1, 29'h1FFF_FFDF);
    check_sel(5, model[5], "R6");
    check_sel(6, model[6], "R6");
    check_sel(3, model[3], "R6");
  endtask

  task automatic t_range;
    cycle(1'b1, 29, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0);
    cycle(1'b1, 31, 64'h0123_4567_89AB_CDEF, 1'b0, '0);
    for (int i = 0; i < N; i += 4) check_sel(i, model[i], "R7");
    check_sel(30, 64'h0, "R7");
    check_sel(31, 64'h0, "R7");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    ovf_load = 1'b0; ovf_vec = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    check_sel(4, 64'h0, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic_write();
    t_ops();
    t_overflow();
    t_collision();
    t_range();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule